// File: doc/BRIEF.md
# In-Memory SIMD Lane Datapath

This block is the vector execution engine that sits between a pair of memory banks. It holds sixteen 16-bit lanes, so one operand is a 256-bit vector the size of a single bank prefetch. It keeps a 16-entry vector register file, split into an A half and a B half of eight entries each. It also keeps sixteen 16-bit scalar registers, split into an addend half and a factor half. A decoded operation arrives with its destination, up to three source selectors and register indices. The operation is executed when the access strobe marks the triggering memory access.

Sources can be a vector register, the bank read bus, or a scalar register, which is repeated into every lane. Results go to a vector register, a scalar register (moves only) or the bank write bus (moves only). Arithmetic is two's-complement with wraparound in each lane. A move can clamp negative lanes to zero as it copies. A combinational read-back port exposes any register for inspection.

Top module: `simd_lane_dp`

## Requirements
- R1: After reset every vector and scalar register reads back as zero and `bank_wvalid_o` is low.
- R2: State changes only in a clock cycle where `strobe_i` is high. Operation codes 5, 6 and 7 change nothing, even with the strobe.
- R3: Operation code 1 (add) writes lane-wise `src0 + src1` modulo 2^16 into the destination. Selector codes are 0 = vector A half, 1 = vector B half, 2 = bank bus, 3 = scalar addend half, 4 = scalar factor half. Lane n occupies bits [16n+15:16n].
- R4: Operation code 2 (multiply) writes the low 16 bits of the lane-wise product `src0 * src1`.
- R5: Operation code 4 (multiply-add) writes lane-wise `src0 * src1 + src2` modulo 2^16 into vector half A or B, as selected.
- R6: Operation code 3 (multiply-accumulate) adds `src0 * src1` into the B-half entry named by the destination index. The destination selector is ignored.
- R7: A scalar source is replicated into all 16 lanes. A factor operand (src0/src1 of multiply, multiply-add and multiply-accumulate) reads the factor half. An addend operand (both sources of add, src2 of multiply-add) reads the addend half. This holds whichever scalar code (3 or 4) is given.
- R8: Operation code 0 (move) copies src0 to a vector register, to a scalar register (lane 0 value), or to the bank bus.
- R9: A move with `relu_i` set writes zero into every lane whose sign bit is set, and copies the other lanes unchanged.
- R10: A bank source needs a read access (`acc_wr_i` = 0), and a bank destination needs a write access (`acc_wr_i` = 1). Otherwise the operation is dropped. A bank move raises `bank_wvalid_o` for the one cycle after the strobe, with the data on `bank_wdata_o`. The data holds until the next bank move.
- R11: An add, multiply or multiply-add whose destination is not a vector register is dropped.
- R12: Read-back is combinational. Selector codes 0/1 return the vector entry, and codes 3/4 return the scalar replicated into all lanes. Any other code returns zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| strobe_i | input | 1 | Marks the memory access that triggers the operation |
| acc_wr_i | input | 1 | Triggering access is a write (1) or a read (0) |
| op_i | input | 3 | Operation code |
| relu_i | input | 1 | Clamp negative lanes on a move |
| dst_sel_i | input | 3 | Destination selector |
| dst_idx_i | input | 3 | Destination index within the half |
| src0_sel_i | input | 3 | Source 0 selector |
| src0_idx_i | input | 3 | Source 0 index |
| src1_sel_i | input | 3 | Source 1 selector |
| src1_idx_i | input | 3 | Source 1 index |
| src2_sel_i | input | 3 | Source 2 selector (multiply-add) |
| src2_idx_i | input | 3 | Source 2 index |
| bank_rdata_i | input | 256 | Bank read data |
| bank_wdata_o | output | 256 | Bank write data |
| bank_wvalid_o | output | 1 | Bank write data valid |
| rb_sel_i | input | 3 | Read-back selector |
| rb_idx_i | input | 3 | Read-back index |
| rb_data_o | output | 256 | Read-back data |

## Verification
The assertions assume that the operation fields and `acc_wr_i` are valid and settled at every rising edge where `strobe_i` is high. They also assume that reset is held for at least one edge before any operation is sent. The stimulus follows these rules. It changes every input on the falling edge and sends one operation per two clock cycles, with the strobe high for exactly one rising edge. It compares results only through the read-back port and the bank write outputs, half a cycle after the edge that stores them.

// File: rtl/simd_dp_pkg.sv
`timescale 1ns/1ps
package simd_dp_pkg;
  localparam int LANE_W = 16;

  typedef enum logic [2:0] {
    OP_MOV = 3'd0, OP_ADD = 3'd1, OP_MUL = 3'd2, OP_MAC = 3'd3, OP_MAD = 3'd4
  } op_e;

  typedef enum logic [2:0] {
    SEL_GRFA = 3'd0, SEL_GRFB = 3'd1, SEL_BANK = 3'd2, SEL_SRFA = 3'd3, SEL_SRFM = 3'd4
  } sel_e;

  function automatic logic [LANE_W-1:0] lane_add(input logic [LANE_W-1:0] a, input logic [LANE_W-1:0] b);
    return a + b;
  endfunction

  function automatic logic [LANE_W-1:0] lane_mul(input logic [LANE_W-1:0] a, input logic [LANE_W-1:0] b);
    return a * b;
  endfunction

  function automatic logic [LANE_W-1:0] lane_fma(input logic [LANE_W-1:0] a, input logic [LANE_W-1:0] b,
                                                 input logic [LANE_W-1:0] c);
    return a * b + c;
  endfunction

  function automatic logic lane_is_neg(input logic [LANE_W-1:0] a);
    return a[LANE_W-1];
  endfunction

  function automatic logic [LANE_W-1:0] lane_clamp(input logic [LANE_W-1:0] a);
    return lane_is_neg(a) ? '0 : a;
  endfunction
endpackage

// File: rtl/simd_rf.sv
`timescale 1ns/1ps
module simd_rf #(
  parameter int DEPTH = 16,
  parameter int WIDTH = 256,
  parameter int NRD   = 2
) (
  input  logic                              clk,
  input  logic                              rst_n,
  input  logic                              we_i,
  input  logic [$clog2(DEPTH)-1:0]          waddr_i,
  input  logic [WIDTH-1:0]                  wdata_i,
  input  logic [NRD-1:0][$clog2(DEPTH)-1:0] raddr_i,
  output logic [NRD-1:0][WIDTH-1:0]         rdata_o
);
  localparam int AW = $clog2(DEPTH);

  logic [WIDTH-1:0] mem_q [DEPTH];

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      for (int k = 0; k < DEPTH; k++) mem_q[k] <= '0;
    end else if (we_i) begin
      mem_q[waddr_i] <= wdata_i;
    end
  end

  for (genvar g = 0; g < NRD; g++) begin : g_rd
    assign rdata_o[g] = mem_q[raddr_i[g]];
  end

  for (genvar e = 0; e < DEPTH; e++) begin : g_hold
    // R2
    rf_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !(we_i && waddr_i == AW'(e)) |=> $stable(mem_q[e]));
  end
endmodule

// File: rtl/simd_lane_alu.sv
`timescale 1ns/1ps
module simd_lane_alu import simd_dp_pkg::*; #(
  parameter int LANES = 16
) (
  input  logic [2:0]              op_i,
  input  logic                    relu_i,
  input  logic [LANES*LANE_W-1:0] a_i,
  input  logic [LANES*LANE_W-1:0] b_i,
  input  logic [LANES*LANE_W-1:0] c_i,
  output logic [LANES*LANE_W-1:0] y_o
);
  for (genvar g = 0; g < LANES; g++) begin : g_lane
    logic [LANE_W-1:0] a_l, b_l, c_l, y_l;
    assign a_l = a_i[g*LANE_W +: LANE_W];
    assign b_l = b_i[g*LANE_W +: LANE_W];
    assign c_l = c_i[g*LANE_W +: LANE_W];

    always_comb begin
      case (op_i)
        OP_MOV:         y_l = relu_i ? lane_clamp(a_l) : a_l;
        OP_ADD:         y_l = lane_add(a_l, b_l);
        OP_MUL:         y_l = lane_mul(a_l, b_l);
        OP_MAC, OP_MAD: y_l = lane_fma(a_l, b_l, c_l);
        default:        y_l = '0;
      endcase
    end

    assign y_o[g*LANE_W +: LANE_W] = y_l;

    always_comb begin
      if (op_i == OP_MOV && relu_i) begin
        // R9
        relu_clamp_chk: assert (!lane_is_neg(y_l));
      end
    end
  end
endmodule

// File: rtl/simd_lane_dp.sv
`timescale 1ns/1ps
module simd_lane_dp import simd_dp_pkg::*; #(
  parameter int LANES      = 16,
  parameter int HALF_DEPTH = 8
) (
  input  logic                          clk,
  input  logic                          rst_n,
  input  logic                          strobe_i,
  input  logic                          acc_wr_i,
  input  logic [2:0]                    op_i,
  input  logic                          relu_i,
  input  logic [2:0]                    dst_sel_i,
  input  logic [$clog2(HALF_DEPTH)-1:0] dst_idx_i,
  input  logic [2:0]                    src0_sel_i,
  input  logic [$clog2(HALF_DEPTH)-1:0] src0_idx_i,
  input  logic [2:0]                    src1_sel_i,
  input  logic [$clog2(HALF_DEPTH)-1:0] src1_idx_i,
  input  logic [2:0]                    src2_sel_i,
  input  logic [$clog2(HALF_DEPTH)-1:0] src2_idx_i,
  input  logic [LANES*LANE_W-1:0]       bank_rdata_i,
  output logic [LANES*LANE_W-1:0]       bank_wdata_o,
  output logic                          bank_wvalid_o,
  input  logic [2:0]                    rb_sel_i,
  input  logic [$clog2(HALF_DEPTH)-1:0] rb_idx_i,
  output logic [LANES*LANE_W-1:0]       rb_data_o
);
  localparam int VW    = LANES * LANE_W;
  localparam int IW    = $clog2(HALF_DEPTH);
  localparam int AW    = IW + 1;
  localparam int DEPTH = 2 * HALF_DEPTH;

  // read port map: vector 0..2 sources, 3 accumulator, 4 read-back; scalar 0..2 sources, 3 read-back
  logic [4:0][AW-1:0]     grf_ra;
  logic [4:0][VW-1:0]     grf_rd;
  logic [3:0][AW-1:0]     srf_ra;
  logic [3:0][LANE_W-1:0] srf_rd;

  logic is_mov, is_add, is_mul, is_mac, is_mad, use1, use2, op_known;
  logic f0_half, f1_half;
  logic dst_grf, dst_srf, dst_bank, bank_src, dst_ok, dir_ok;
  logic exec_fire, grf_we, srf_we, bank_we;
  logic [AW-1:0] grf_wa, srf_wa;
  logic [VW-1:0] opnd0, opnd1, opnd2, alu_c, alu_y;

  assign is_mov   = (op_i == OP_MOV);
  assign is_add   = (op_i == OP_ADD);
  assign is_mul   = (op_i == OP_MUL);
  assign is_mac   = (op_i == OP_MAC);
  assign is_mad   = (op_i == OP_MAD);
  assign use1     = is_add | is_mul | is_mac | is_mad;
  assign use2     = is_mad;
  assign op_known = use1 | is_mov;

  // scalar half per operand role: 1 = factor half, 0 = addend half
  assign f0_half = is_mov ? (src0_sel_i == SEL_SRFM) : !is_add;
  assign f1_half = !is_add;

  assign grf_ra[0] = {src0_sel_i == SEL_GRFB, src0_idx_i};
  assign grf_ra[1] = {src1_sel_i == SEL_GRFB, src1_idx_i};
  assign grf_ra[2] = {src2_sel_i == SEL_GRFB, src2_idx_i};
  assign grf_ra[3] = {1'b1, dst_idx_i};
  assign grf_ra[4] = {rb_sel_i == SEL_GRFB, rb_idx_i};
  assign srf_ra[0] = {f0_half, src0_idx_i};
  assign srf_ra[1] = {f1_half, src1_idx_i};
  assign srf_ra[2] = {1'b0, src2_idx_i};
  assign srf_ra[3] = {rb_sel_i == SEL_SRFM, rb_idx_i};

  function automatic logic [VW-1:0] pick(input logic [2:0] sel, input logic [VW-1:0] g,
                                         input logic [LANE_W-1:0] s, input logic [VW-1:0] bank);
    case (sel)
      SEL_GRFA, SEL_GRFB: return g;
      SEL_BANK:           return bank;
      SEL_SRFA, SEL_SRFM: return {LANES{s}};
      default:            return '0;
    endcase
  endfunction

  assign opnd0 = pick(src0_sel_i, grf_rd[0], srf_rd[0], bank_rdata_i);
  assign opnd1 = pick(src1_sel_i, grf_rd[1], srf_rd[1], bank_rdata_i);
  assign opnd2 = pick(src2_sel_i, grf_rd[2], srf_rd[2], bank_rdata_i);
  assign alu_c = is_mac ? grf_rd[3] : opnd2;

  assign dst_grf  = (dst_sel_i == SEL_GRFA) || (dst_sel_i == SEL_GRFB);
  assign dst_srf  = (dst_sel_i == SEL_SRFA) || (dst_sel_i == SEL_SRFM);
  assign dst_bank = (dst_sel_i == SEL_BANK);
  assign bank_src = (src0_sel_i == SEL_BANK) || (use1 && src1_sel_i == SEL_BANK) ||
                    (use2 && src2_sel_i == SEL_BANK);
  assign dst_ok   = is_mac || (is_mov ? (dst_grf || dst_srf || dst_bank) : dst_grf);
  assign dir_ok   = !(bank_src && acc_wr_i) && !(is_mov && dst_bank && !acc_wr_i);

  assign exec_fire = strobe_i && op_known && dst_ok && dir_ok;
  assign grf_we    = exec_fire && (is_mac || dst_grf);
  assign srf_we    = exec_fire && is_mov && dst_srf;
  assign bank_we   = exec_fire && is_mov && dst_bank;
  assign grf_wa    = {is_mac || (dst_sel_i == SEL_GRFB), dst_idx_i};
  assign srf_wa    = {dst_sel_i == SEL_SRFM, dst_idx_i};

  simd_lane_alu #(.LANES(LANES)) u_alu (
    .op_i(op_i), .relu_i(relu_i), .a_i(opnd0), .b_i(opnd1), .c_i(alu_c), .y_o(alu_y)
  );

  simd_rf #(.DEPTH(DEPTH), .WIDTH(VW), .NRD(5)) u_grf (
    .clk(clk), .rst_n(rst_n), .we_i(grf_we), .waddr_i(grf_wa), .wdata_i(alu_y),
    .raddr_i(grf_ra), .rdata_o(grf_rd)
  );

  simd_rf #(.DEPTH(DEPTH), .WIDTH(LANE_W), .NRD(4)) u_srf (
    .clk(clk), .rst_n(rst_n), .we_i(srf_we), .waddr_i(srf_wa), .wdata_i(alu_y[LANE_W-1:0]),
    .raddr_i(srf_ra), .rdata_o(srf_rd)
  );

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      bank_wvalid_o <= 1'b0;
      bank_wdata_o  <= '0;
    end else begin
      bank_wvalid_o <= bank_we;
      if (bank_we) bank_wdata_o <= alu_y;
    end
  end

  always_comb begin
    case (rb_sel_i)
      SEL_GRFA, SEL_GRFB: rb_data_o = grf_rd[4];
      SEL_SRFA, SEL_SRFM: rb_data_o = {LANES{srf_rd[3]}};
      default:            rb_data_o = '0;
    endcase
  end

  // R2
  strobe_gate_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (grf_we || srf_we || bank_we) |-> strobe_i);
  // R10
  wr_dir_chk: assert property (@(posedge clk) disable iff (!rst_n)
    bank_wvalid_o |-> $past(strobe_i && acc_wr_i));
  // R10
  rd_dir_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ((grf_we || srf_we) && bank_src) |-> !acc_wr_i);
  // R10
  wdata_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !bank_we |=> $stable(bank_wdata_o));
  // R8
  one_target_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({grf_we, srf_we, bank_we}));
endmodule

// File: tb/simd_lane_dp_tb.sv
`timescale 1ns/1ps
module simd_lane_dp_tb;
  localparam int VW = 256;
  localparam logic [2:0] K_MOV = 3'd0, K_ADD = 3'd1, K_MUL = 3'd2, K_MAC = 3'd3, K_MAD = 3'd4;
  localparam logic [2:0] K_GA = 3'd0, K_GB = 3'd1, K_BK = 3'd2, K_SA = 3'd3, K_SM = 3'd4;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  always #2 clk = ~clk;

  logic strobe, acc_wr, relu, wvalid;
  logic [2:0] op, dsel, didx, s0, i0, s1, i1, s2, i2, rbs, rbi;
  logic [VW-1:0] bank_in, wdata, rb_data;

  simd_lane_dp u_dut (
    .clk(clk), .rst_n(rst_n), .strobe_i(strobe), .acc_wr_i(acc_wr), .op_i(op), .relu_i(relu),
    .dst_sel_i(dsel), .dst_idx_i(didx), .src0_sel_i(s0), .src0_idx_i(i0),
    .src1_sel_i(s1), .src1_idx_i(i1), .src2_sel_i(s2), .src2_idx_i(i2),
    .bank_rdata_i(bank_in), .bank_wdata_o(wdata), .bank_wvalid_o(wvalid),
    .rb_sel_i(rbs), .rb_idx_i(rbi), .rb_data_o(rb_data)
  );

  int n_chk = 0, n_bad = 0;
  bit done = 1'b0;
  logic [VW-1:0] mg [16];
  logic [15:0]   ms [16];

  function automatic logic [VW-1:0] calc(input int kind, input logic [VW-1:0] a, input logic [VW-1:0] b,
                                         input logic [VW-1:0] c);
    logic [VW-1:0] r;
    for (int l = 0; l < 16; l++) begin
      longint x, y, z, v;
      x = longint'(a[16*l +: 16]); y = longint'(b[16*l +: 16]); z = longint'(c[16*l +: 16]);
      v = (kind == 1) ? x + y : (kind == 2) ? x * y : x * y + z;
      r[16*l +: 16] = 16'(v % 65536);
    end
    return r;
  endfunction

  function automatic logic [VW-1:0] pat(input int seed);
    logic [VW-1:0] r;
    for (int l = 0; l < 16; l++) r[16*l +: 16] = 16'(seed * 4099 + l * 771 + l * l * 13);
    return r;
  endfunction

  function automatic logic [VW-1:0] bcast(input logic [15:0] s);
    return {16{s}};
  endfunction

  function automatic logic [VW-1:0] clampv(input logic [VW-1:0] v);
    logic [VW-1:0] r;
    for (int l = 0; l < 16; l++) r[16*l +: 16] = ($signed(v[16*l +: 16]) < 0) ? 16'd0 : v[16*l +: 16];
    return r;
  endfunction

  task automatic check(input string req, input string what, input logic [VW-1:0] act, input logic [VW-1:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s %s: got %h expected %h", req, what, act, exp);
    end
  endtask

  task automatic readback(input logic [2:0] sel, input logic [2:0] idx, output logic [VW-1:0] v);
    rbs = sel; rbi = idx; #1; v = rb_data;
  endtask

  task automatic check_grf(input string req, input int a);
    logic [VW-1:0] v;
    readback(a >= 8 ? K_GB : K_GA, 3'(a % 8), v);
    check(req, $sformatf("vector entry %0d", a), v, mg[a]);
  endtask

  task automatic check_srf(input string req, input int a);
    logic [VW-1:0] v;
    readback(a >= 8 ? K_SM : K_SA, 3'(a % 8), v);
    check(req, $sformatf("scalar entry %0d", a), v, bcast(ms[a]));
  endtask

  task automatic drive(input logic [2:0] o, input logic [2:0] ds, input logic [2:0] di,
                       input logic [2:0] a0, input logic [2:0] x0, input logic [2:0] a1, input logic [2:0] x1,
                       input logic [2:0] a2, input logic [2:0] x2, input logic rl, input logic wr,
                       input logic [VW-1:0] bk, input logic stb = 1'b1);
    @(negedge clk);
    op = o; dsel = ds; didx = di; s0 = a0; i0 = x0; s1 = a1; i1 = x1; s2 = a2; i2 = x2;
    relu = rl; acc_wr = wr; bank_in = bk; strobe = stb;
    @(negedge clk);
    strobe = 1'b0;
  endtask

  task automatic t_reset;
    logic [VW-1:0] v;
    for (int a = 0; a < 16; a++) begin check_grf("R1", a); check_srf("R1", a); end
    check("R1", "wvalid after reset", VW'(wvalid), '0);
    readback(3'd6, 3'd0, v);
    check("R12", "unused read-back code", v, '0);
  endtask

  task automatic t_fill;
    for (int a = 0; a < 16; a++) begin
      drive(K_MOV, a >= 8 ? K_GB : K_GA, 3'(a % 8), K_BK, 0, K_GA, 0, K_GA, 0, 0, 0, pat(a + 1));
      mg[a] = pat(a + 1);
    end
    for (int a = 0; a < 16; a++) check_grf("R8", a);
    for (int a = 0; a < 16; a++) begin
      logic [VW-1:0] bk;
      bk = pat(a + 40);
      bk[15:0] = 16'(a * 3 + 2);
      drive(K_MOV, a >= 8 ? K_SM : K_SA, 3'(a % 8), K_BK, 0, K_GA, 0, K_GA, 0, 0, 0, bk);
      ms[a] = 16'(a * 3 + 2);
    end
    for (int a = 0; a < 16; a++) check_srf("R12", a);
  endtask

  task automatic t_add;
    drive(K_MOV, K_GA, 0, K_BK, 0, K_GA, 0, K_GA, 0, 0, 0, {16{16'hFFFF}});
    mg[0] = {16{16'hFFFF}};
    drive(K_ADD, K_GA, 2, K_GA, 0, K_GA, 1, K_GA, 0, 0, 0, '0);
    mg[2] = calc(1, mg[0], mg[1], '0);
    check_grf("R3", 2);
    drive(K_ADD, K_GB, 2, K_GB, 3, K_GA, 5, K_GA, 0, 0, 0, '0);
    mg[10] = calc(1, mg[11], mg[5], '0);
    check_grf("R3", 10);
    // addend operand given the factor-half code still reads the addend half
    drive(K_ADD, K_GA, 3, K_GA, 1, K_SM, 4, K_GA, 0, 0, 0, '0);
    mg[3] = calc(1, mg[1], bcast(ms[4]), '0);
    check_grf("R7", 3);
  endtask

  task automatic t_mul;
    drive(K_MUL, K_GB, 3, K_GA, 1, K_SA, 5, K_GA, 0, 0, 0, '0);
    mg[11] = calc(2, mg[1], bcast(ms[13]), '0);
    check_grf("R7", 11);
    drive(K_MUL, K_GA, 3, K_GA, 3, K_GB, 4, K_GA, 0, 0, 0, '0);
    mg[3] = calc(2, mg[3], mg[12], '0);
    check_grf("R4", 3);
  endtask

  task automatic t_mad;
    drive(K_MAD, K_GA, 4, K_GA, 1, K_GB, 0, K_SM, 2, 0, 0, '0);
    mg[4] = calc(3, mg[1], mg[8], bcast(ms[2]));
    check_grf("R5", 4);
    drive(K_MAD, K_GB, 5, K_GB, 1, K_GA, 2, K_GA, 6, 0, 0, '0);
    mg[13] = calc(3, mg[9], mg[2], mg[6]);
    check_grf("R5", 13);
  endtask

  task automatic t_mac;
    drive(K_MAC, K_GA, 6, K_BK, 0, K_GA, 1, K_GA, 0, 0, 0, pat(77));
    mg[14] = calc(3, pat(77), mg[1], mg[14]);
    drive(K_MAC, K_GA, 6, K_BK, 0, K_GA, 1, K_GA, 0, 0, 0, pat(91));
    mg[14] = calc(3, pat(91), mg[1], mg[14]);
    check_grf("R6", 14);
    check_grf("R6", 6);
    drive(K_MAC, K_GB, 6, K_GA, 2, K_SA, 1, K_GA, 0, 0, 0, '0);
    mg[14] = calc(3, mg[2], bcast(ms[9]), mg[14]);
    check_grf("R7", 14);
  endtask

  task automatic t_relu;
    logic [VW-1:0] mix;
    for (int l = 0; l < 16; l++) mix[16*l +: 16] = (l % 2 == 1) ? 16'(16'h8000 + l * 5) : 16'(l * 9 + 1);
    mix[16*15 +: 16] = 16'hFFFF;
    drive(K_MOV, K_GB, 1, K_BK, 0, K_GA, 0, K_GA, 0, 0, 0, mix);
    mg[9] = mix;
    drive(K_MOV, K_GA, 7, K_GB, 1, K_GA, 0, K_GA, 0, 1, 0, '0);
    mg[7] = clampv(mix);
    check_grf("R9", 7);
    drive(K_MOV, K_GB, 7, K_GB, 1, K_GA, 0, K_GA, 0, 0, 0, '0);
    mg[15] = mix;
    check_grf("R8", 15);
  endtask

  task automatic t_bank;
    drive(K_MOV, K_BK, 0, K_GA, 2, K_GA, 0, K_GA, 0, 0, 1, '0);
    check("R10", "wvalid after bank move", VW'(wvalid), VW'(1));
    check("R10", "bank write data", wdata, mg[2]);
    @(negedge clk);
    check("R10", "wvalid one cycle later", VW'(wvalid), '0);
    check("R10", "bank data held", wdata, mg[2]);
  endtask

  task automatic t_dir;
    drive(K_MOV, K_GA, 0, K_BK, 0, K_GA, 0, K_GA, 0, 0, 1, pat(123));
    check_grf("R10", 0);
    drive(K_MOV, K_BK, 0, K_GA, 4, K_GA, 0, K_GA, 0, 0, 0, '0);
    check("R10", "bank move on read access", VW'(wvalid), '0);
    check("R10", "bank data kept", wdata, mg[2]);
    drive(K_MAC, K_GB, 6, K_BK, 0, K_GA, 1, K_GA, 0, 0, 1, pat(5));
    check_grf("R10", 14);
  endtask

  task automatic t_gate;
    drive(K_ADD, K_GA, 5, K_GA, 1, K_GA, 2, K_GA, 0, 0, 0, '0, 1'b0);
    @(negedge clk);
    check_grf("R2", 5);
    drive(3'd5, K_GA, 5, K_GA, 1, K_GA, 2, K_GA, 0, 0, 0, '0);
    check_grf("R2", 5);
    drive(3'd7, K_BK, 0, K_GA, 1, K_GA, 2, K_GA, 0, 0, 1, '0);
    check("R2", "wvalid for unused code", VW'(wvalid), '0);
    check_grf("R2", 5);
  endtask

  task automatic t_dst;
    drive(K_ADD, K_BK, 0, K_GA, 1, K_GA, 2, K_GA, 0, 0, 1, '0);
    check("R11", "wvalid for add to bank", VW'(wvalid), '0);
    drive(K_ADD, K_SA, 1, K_GA, 1, K_GA, 2, K_GA, 0, 0, 0, '0);
    check_srf("R11", 1);
    drive(K_MUL, K_SM, 0, K_GA, 1, K_GA, 2, K_GA, 0, 0, 0, '0);
    check_srf("R11", 8);
  endtask

  initial begin
    strobe = 0; acc_wr = 0; relu = 0; op = 0; dsel = 0; didx = 0;
    s0 = 0; i0 = 0; s1 = 0; i1 = 0; s2 = 0; i2 = 0; rbs = 0; rbi = 0; bank_in = '0;
    for (int a = 0; a < 16; a++) begin mg[a] = '0; ms[a] = '0; end
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    t_reset; t_fill; t_add; t_mul; t_mad; t_mac; t_relu; t_bank; t_dir; t_gate; t_dst;
    done = 1'b1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      n_chk++; n_bad++;
      $display("FAIL all-requirements watchdog: got timeout expected completion");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
    end
  end
endmodule